// File: doc/BRIEF.md
# DRAM Bank Timing Rule Checker

This block watches the command bus of a four-bank DDR2-style memory device and reports any command that breaks a row-timing rule. It decodes activate, read, write, precharge and refresh from the registered command strobes. It keeps, for each bank, whether a row is open and how many cycles have passed since that bank's last activate and last precharge. When a command arrives too early, or when a row stays open too long, it raises a one-cycle pulse on the output for the rule that was broken. It also raises a pulse when the gap between refresh commands exceeds the allowed interval.

Every limit is set in picoseconds, together with the clock period. At elaboration each limit becomes a cycle count: the limit divided by the period, rounded up. Every violation pulse is registered. It goes high in the cycle that follows the clock edge that captured the offending command or condition, and it lasts one cycle. The bank-open vector is a live view of the tracked row state, and simulation checkers or debug logic can use it.

Top module: `dram_bank_timing_monitor`

## Requirements
- R1: Command encoding on (sel_n, row_n, col_n, wr_n): activate 0011, read 0101, write 0100, precharge 0010, refresh 0001. When sel_n is high, or the pattern is any other value (for example 0000, 0111, 0110), the block changes no bank state and raises no command-related violation.
- R2: After the clock edge that captures an activate, bit `bank_addr` of `bank_open` is set. A precharge with `addr_b10` = 0 clears only the addressed bit. A precharge with `addr_b10` = 1 clears every bit. After reset, `bank_open` is all zero.
- R3: A read or write to an open bank fewer than ACT_RW cycles after that bank's activate pulses `err_act_to_rw`. All violation pulses are high for one cycle, starting in the cycle after the capturing edge.
- R4: An activate fewer than PRE_ACT cycles after that bank's last effective precharge pulses `err_pre_to_act`.
- R5: An activate fewer than ACT_ACT cycles after that bank's previous activate pulses `err_act_to_act`.
- R6: A precharge that closes a bank fewer than OPEN_MIN cycles after its activate pulses `err_open_short`. An all-bank precharge checks each open bank separately.
- R7: A bank that is still open OPEN_MAX+1 cycles after its activate pulses `err_open_long` once, in the cycle after that edge. A row open for exactly OPEN_MAX cycles is legal.
- R8: When REF_INTV+1 cycles pass since the last refresh, `err_refresh_late` pulses once. Reset counts as a refresh on the last edge before the first active edge. Every refresh restarts the interval.
- R9: `err_protocol` pulses for a read or write to a closed bank, an activate to an open bank, or a refresh while any bank is open.
- R10: Each cycle limit equals ceil(limit_ps / CLK_PERIOD_PS). For example, 12500 ps at a 5000 ps period gives 3 cycles.
- R11: A precharge addressed to a closed bank has no effect. It raises no violation and does not restart that bank's precharge-to-activate timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low; commands are ignored when high |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write-enable strobe, active low |
| bank_addr | input | BANK_W (2) | Target bank of activate, read, write and precharge |
| addr_b10 | input | 1 | During precharge: 1 = all banks, 0 = addressed bank |
| bank_open | output | NUM_BANKS (4) | One bit per bank, set while a row is open |
| err_act_to_rw | output | 1 | Activate-to-read/write violation pulse |
| err_pre_to_act | output | 1 | Precharge-to-activate violation pulse |
| err_act_to_act | output | 1 | Row-cycle violation pulse |
| err_open_short | output | 1 | Row closed too soon |
| err_open_long | output | 1 | Row held open too long |
| err_refresh_late | output | 1 | Refresh interval exceeded |
| err_protocol | output | 1 | Command illegal for the current row state |

## Verification
The bound assertions check, on every cycle, several things: deselected or unknown commands leave the row state and the command-related flags untouched; an activate opens its bank; an all-bank precharge closes everything; a read or write to a closed bank, or a refresh while a bank is open, is flagged; the refresh-late pulse never lasts two cycles; and a row-held-open pulse needs a bank that was open. The exact cycle boundaries only show up in the bench's directed and random sequences, compared against a timestamp model. These are the rounded-up limits, the one-cycle-late legality of each rule, the single long-open pulse at OPEN_MAX+1, and the fact that a precharge to an idle bank does not restart the precharge timer.

// File: rtl/bank_mon_pkg.sv
package bank_mon_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF
   } cmd_e;

   // Per-bank violation flags, produced combinationally before registering.
   typedef struct packed {
      logic act_rw;
      logic pre_act;
      logic act_act;
      logic open_short;
      logic open_long;
      logic proto;
   } bank_err_t;

   // Limit in picoseconds to clock cycles, rounded up.
   function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                             input int unsigned clk_ps);
      longint unsigned num;
      num = longint'(t_ps) + longint'(clk_ps) - 64'd1;
      return int'(num / longint'(clk_ps));
   endfunction

endpackage

// File: rtl/bank_mon_decode.sv
module bank_mon_decode
   import bank_mon_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 2
) (
   input  logic                 sel_n,
   input  logic                 row_n,
   input  logic                 col_n,
   input  logic                 wr_n,
   input  logic [BANK_W-1:0]    bank_addr,
   input  logic                 addr_b10,
   output cmd_e                 cmd,
   output logic [NUM_BANKS-1:0] bank_hit,
   output logic                 pre_all
);

   always_comb begin
      cmd = CMD_NONE;
      if (!sel_n) begin
         case ({row_n, col_n, wr_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_NONE;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
      assign bank_hit[g] = (bank_addr == BANK_W'(g));
   end

   assign pre_all = (cmd == CMD_PRE) && addr_b10;

endmodule

// File: rtl/bank_mon_age.sv
module bank_mon_age #(
   parameter int unsigned W    = 8,
   parameter int unsigned SAT  = 255,
   parameter int unsigned INIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] age
);

   localparam logic [W-1:0] SAT_V  = W'(SAT);
   localparam logic [W-1:0] INIT_V = W'(INIT);
   localparam logic [W-1:0] ONE_V  = W'(1);

   if (W == 0 || W > 31) begin : g_bad_width
      $error("bank_mon_age: width out of range");
   end
   if (longint'(SAT) >= (longint'(1) << W)) begin : g_bad_sat
      $error("bank_mon_age: saturation value does not fit width");
   end
   if (INIT > SAT) begin : g_bad_init
      $error("bank_mon_age: reset value above saturation");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age <= INIT_V;
      end else if (restart) begin
         age <= ONE_V;
      end else if (age != SAT_V) begin
         age <= age + ONE_V;
      end
   end

endmodule

// File: rtl/bank_mon_bank.sv
module bank_mon_bank
   import bank_mon_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned ACT_RW_CYC   = 3,
   parameter int unsigned PRE_ACT_CYC  = 3,
   parameter int unsigned ACT_ACT_CYC  = 12,
   parameter int unsigned OPEN_MIN_CYC = 9,
   parameter int unsigned OPEN_MAX_CYC = 200
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      do_act,
   input  logic      do_rw,
   input  logic      do_pre,
   output logic      is_open,
   output bank_err_t err
);

   localparam int unsigned SAT = OPEN_MAX_CYC + 2;
   localparam logic [CNT_W-1:0] ACT_RW_V   = CNT_W'(ACT_RW_CYC);
   localparam logic [CNT_W-1:0] PRE_ACT_V  = CNT_W'(PRE_ACT_CYC);
   localparam logic [CNT_W-1:0] ACT_ACT_V  = CNT_W'(ACT_ACT_CYC);
   localparam logic [CNT_W-1:0] OPEN_MIN_V = CNT_W'(OPEN_MIN_CYC);
   localparam logic [CNT_W-1:0] OPEN_END_V = CNT_W'(OPEN_MAX_CYC + 1);

   logic [CNT_W-1:0] act_age;
   logic [CNT_W-1:0] pre_age;
   logic             close_now;

   // Precharge only counts when it actually closes a row.
   assign close_now = do_pre && is_open;

   bank_mon_age #(.W(CNT_W), .SAT(SAT), .INIT(SAT)) u_act_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (do_act),
      .age     (act_age)
   );

   bank_mon_age #(.W(CNT_W), .SAT(SAT), .INIT(SAT)) u_pre_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (close_now),
      .age     (pre_age)
   );

   always_comb begin
      err            = '0;
      err.act_act    = do_act && (act_age < ACT_ACT_V);
      err.pre_act    = do_act && (pre_age < PRE_ACT_V);
      err.act_rw     = do_rw && is_open && (act_age < ACT_RW_V);
      err.open_short = close_now && (act_age < OPEN_MIN_V);
      err.open_long  = is_open && (act_age == OPEN_END_V);
      err.proto      = (do_act && is_open) || (do_rw && !is_open);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
      end else if (do_act) begin
         is_open <= 1'b1;
      end else if (close_now) begin
         is_open <= 1'b0;
      end
   end

endmodule

// File: rtl/bank_mon_refresh.sv
module bank_mon_refresh #(
   parameter int unsigned REF_CYC = 1560,
   parameter int unsigned REF_W   = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_ref,
   input  logic any_open,
   output logic late,
   output logic proto
);

   localparam int unsigned SAT = REF_CYC + 2;
   localparam logic [REF_W-1:0] END_V = REF_W'(REF_CYC + 1);

   logic [REF_W-1:0] ref_age;

   // Reset behaves as a refresh on the edge before the first active one.
   bank_mon_age #(.W(REF_W), .SAT(SAT), .INIT(1)) u_ref_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (do_ref),
      .age     (ref_age)
   );

   assign late  = (ref_age == END_V);
   assign proto = do_ref && any_open;

endmodule

// File: rtl/dram_bank_timing_monitor.sv
module dram_bank_timing_monitor
   import bank_mon_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 4,
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned T_ACT_RW_PS   = 15000,
   parameter int unsigned T_PRE_ACT_PS  = 15000,
   parameter int unsigned T_ACT_ACT_PS  = 60000,
   parameter int unsigned T_OPEN_MIN_PS = 45000,
   parameter int unsigned T_OPEN_MAX_PS = 70000000,
   parameter int unsigned T_REF_INTV_PS = 7800000,
   localparam int unsigned BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic                 row_n,
   input  logic                 col_n,
   input  logic                 wr_n,
   input  logic [BANK_W-1:0]    bank_addr,
   input  logic                 addr_b10,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic                 err_act_to_rw,
   output logic                 err_pre_to_act,
   output logic                 err_act_to_act,
   output logic                 err_open_short,
   output logic                 err_open_long,
   output logic                 err_refresh_late,
   output logic                 err_protocol
);

   localparam int unsigned ACT_RW_CYC   = ps_to_cyc(T_ACT_RW_PS,   CLK_PERIOD_PS);
   localparam int unsigned PRE_ACT_CYC  = ps_to_cyc(T_PRE_ACT_PS,  CLK_PERIOD_PS);
   localparam int unsigned ACT_ACT_CYC  = ps_to_cyc(T_ACT_ACT_PS,  CLK_PERIOD_PS);
   localparam int unsigned OPEN_MIN_CYC = ps_to_cyc(T_OPEN_MIN_PS, CLK_PERIOD_PS);
   localparam int unsigned OPEN_MAX_CYC = ps_to_cyc(T_OPEN_MAX_PS, CLK_PERIOD_PS);
   localparam int unsigned REF_CYC      = ps_to_cyc(T_REF_INTV_PS, CLK_PERIOD_PS);
   localparam int unsigned CNT_W        = $clog2(OPEN_MAX_CYC + 3);
   localparam int unsigned REF_W        = $clog2(REF_CYC + 3);

   // Elaboration-time parameter checks.
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("bank count must be a power of two, at least 2");
   end
   if (CLK_PERIOD_PS == 0) begin : g_bad_period
      $error("clock period must be non-zero");
   end
   if (ACT_RW_CYC == 0 || PRE_ACT_CYC == 0 || ACT_ACT_CYC == 0 ||
       OPEN_MIN_CYC == 0 || REF_CYC == 0) begin : g_bad_zero
      $error("every timing limit must be at least one cycle");
   end
   if (OPEN_MIN_CYC > OPEN_MAX_CYC || ACT_ACT_CYC > OPEN_MAX_CYC ||
       ACT_RW_CYC > OPEN_MAX_CYC || PRE_ACT_CYC > OPEN_MAX_CYC) begin : g_bad_order
      $error("minimum limits must not exceed the maximum open time");
   end

   cmd_e                 cmd;
   logic [NUM_BANKS-1:0] bank_hit;
   logic                 pre_all;

   bank_mon_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_decode (
      .sel_n     (sel_n),
      .row_n     (row_n),
      .col_n     (col_n),
      .wr_n      (wr_n),
      .bank_addr (bank_addr),
      .addr_b10  (addr_b10),
      .cmd       (cmd),
      .bank_hit  (bank_hit),
      .pre_all   (pre_all)
   );

   logic [NUM_BANKS-1:0] open_vec;
   logic [NUM_BANKS-1:0] v_act_rw, v_pre_act, v_act_act;
   logic [NUM_BANKS-1:0] v_short, v_long, v_proto;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      bank_err_t be;
      logic      b_act, b_rw, b_pre;

      assign b_act = (cmd == CMD_ACT) && bank_hit[g];
      assign b_rw  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && bank_hit[g];
      assign b_pre = (cmd == CMD_PRE) && (pre_all || bank_hit[g]);

      bank_mon_bank #(
         .CNT_W        (CNT_W),
         .ACT_RW_CYC   (ACT_RW_CYC),
         .PRE_ACT_CYC  (PRE_ACT_CYC),
         .ACT_ACT_CYC  (ACT_ACT_CYC),
         .OPEN_MIN_CYC (OPEN_MIN_CYC),
         .OPEN_MAX_CYC (OPEN_MAX_CYC)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .do_act  (b_act),
         .do_rw   (b_rw),
         .do_pre  (b_pre),
         .is_open (open_vec[g]),
         .err     (be)
      );

      assign v_act_rw[g]  = be.act_rw;
      assign v_pre_act[g] = be.pre_act;
      assign v_act_act[g] = be.act_act;
      assign v_short[g]   = be.open_short;
      assign v_long[g]    = be.open_long;
      assign v_proto[g]   = be.proto;
   end

   logic ref_late, ref_proto;

   bank_mon_refresh #(.REF_CYC(REF_CYC), .REF_W(REF_W)) u_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_ref   (cmd == CMD_REF),
      .any_open (|open_vec),
      .late     (ref_late),
      .proto    (ref_proto)
   );

   assign bank_open = open_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_act_to_rw    <= 1'b0;
         err_pre_to_act   <= 1'b0;
         err_act_to_act   <= 1'b0;
         err_open_short   <= 1'b0;
         err_open_long    <= 1'b0;
         err_refresh_late <= 1'b0;
         err_protocol     <= 1'b0;
      end else begin
         err_act_to_rw    <= |v_act_rw;
         err_pre_to_act   <= |v_pre_act;
         err_act_to_act   <= |v_act_act;
         err_open_short   <= |v_short;
         err_open_long    <= |v_long;
         err_refresh_late <= ref_late;
         err_protocol     <= (|v_proto) || ref_proto;
      end
   end

endmodule

// File: rtl/bank_mon_checker.sv
module bank_mon_checker #(
   parameter int unsigned NUM_BANKS = 4,
   localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sel_n,
   input logic                 row_n,
   input logic                 col_n,
   input logic                 wr_n,
   input logic [BANK_W-1:0]    bank_addr,
   input logic                 addr_b10,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic                 err_act_to_rw,
   input logic                 err_pre_to_act,
   input logic                 err_act_to_act,
   input logic                 err_open_short,
   input logic                 err_open_long,
   input logic                 err_refresh_late,
   input logic                 err_protocol
);

   logic c_act, c_rw, c_pre, c_ref, c_quiet, tgt_open;

   assign c_act    = !sel_n && ({row_n, col_n, wr_n} == 3'b011);
   assign c_rw     = !sel_n && (row_n && !col_n);
   assign c_pre    = !sel_n && ({row_n, col_n, wr_n} == 3'b010);
   assign c_ref    = !sel_n && ({row_n, col_n, wr_n} == 3'b001);
   assign c_quiet  = !(c_act || c_rw || c_pre || c_ref);
   assign tgt_open = bank_open[bank_addr];

   assert_ignored_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(c_quiet)) |->
      ($stable(bank_open) && !err_protocol && !err_act_to_rw && !err_pre_to_act &&
       !err_act_to_act && !err_open_short));

   assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(c_act)) |-> bank_open[$past(bank_addr)]);

   assert_pre_all_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(c_pre) && $past(addr_b10)) |-> (bank_open == '0));

   assert_access_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(c_rw) && !$past(tgt_open)) |-> err_protocol);

   assert_refresh_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(c_ref) && ($past(bank_open) != '0)) |-> err_protocol);

   assert_refresh_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_refresh_late |=> !err_refresh_late);

   assert_long_needs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && err_open_long) |-> ($past(bank_open) != '0));

endmodule

bind dram_bank_timing_monitor bank_mon_checker #(.NUM_BANKS(NUM_BANKS)) u_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .sel_n            (sel_n),
   .row_n            (row_n),
   .col_n            (col_n),
   .wr_n             (wr_n),
   .bank_addr        (bank_addr),
   .addr_b10         (addr_b10),
   .bank_open        (bank_open),
   .err_act_to_rw    (err_act_to_rw),
   .err_pre_to_act   (err_pre_to_act),
   .err_act_to_act   (err_act_to_act),
   .err_open_short   (err_open_short),
   .err_open_long    (err_open_long),
   .err_refresh_late (err_refresh_late),
   .err_protocol     (err_protocol)
);

// File: tb/dram_bank_timing_monitor_tb.sv
`timescale 1ns/1ps
module dram_bank_timing_monitor_tb;

   localparam int unsigned P_PS      = 5000;
   localparam int unsigned ACTRW_PS  = 12500;
   localparam int unsigned PREACT_PS = 15000;
   localparam int unsigned ACTACT_PS = 57500;
   localparam int unsigned OMIN_PS   = 45000;
   localparam int unsigned OMAX_PS   = 1000000;
   localparam int unsigned REFI_PS   = 2500000;

   function automatic int ceil_cyc(input int unsigned t);
      return int'((t + P_PS - 1) / P_PS);
   endfunction

   localparam int E_ACTRW  = ceil_cyc(ACTRW_PS);
   localparam int E_PREACT = ceil_cyc(PREACT_PS);
   localparam int E_ACTACT = ceil_cyc(ACTACT_PS);
   localparam int E_OMIN   = ceil_cyc(OMIN_PS);
   localparam int E_OMAX   = ceil_cyc(OMAX_PS);
   localparam int E_REFI   = ceil_cyc(REFI_PS);

   localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                          C_PRE = 4'b0010, C_REF = 4'b0001, C_NOP = 4'b0111,
                          C_MRS = 4'b0000, C_BST = 4'b0110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
   logic [1:0] bank_addr = '0;
   logic       addr_b10 = 1'b0;
   logic [3:0] bank_open;
   logic       err_act_to_rw, err_pre_to_act, err_act_to_act, err_open_short;
   logic       err_open_long, err_refresh_late, err_protocol;

   always #2.5 clk = ~clk;

   dram_bank_timing_monitor #(
      .NUM_BANKS(4), .CLK_PERIOD_PS(P_PS), .T_ACT_RW_PS(ACTRW_PS),
      .T_PRE_ACT_PS(PREACT_PS), .T_ACT_ACT_PS(ACTACT_PS), .T_OPEN_MIN_PS(OMIN_PS),
      .T_OPEN_MAX_PS(OMAX_PS), .T_REF_INTV_PS(REFI_PS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n),
      .wr_n(wr_n), .bank_addr(bank_addr), .addr_b10(addr_b10), .bank_open(bank_open),
      .err_act_to_rw(err_act_to_rw), .err_pre_to_act(err_pre_to_act),
      .err_act_to_act(err_act_to_act), .err_open_short(err_open_short),
      .err_open_long(err_open_long), .err_refresh_late(err_refresh_late),
      .err_protocol(err_protocol)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int act_t[4];
   int pre_t[4];
   bit m_open[4];
   int ref_t = 0;
   bit done = 1'b0;

   function automatic logic [6:0] got_vec();
      return {err_act_to_rw, err_pre_to_act, err_act_to_act, err_open_short,
              err_open_long, err_refresh_late, err_protocol};
   endfunction

   // One cycle: drive command, predict, clock, compare every output.
   task automatic issue(input logic [3:0] pins, input int b, input bit ap, input string ctx);
      logic [6:0] e;
      logic [3:0] eopen;
      int now;
      string tags[7];
      tags = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9"};
      now = cyc + 1;
      e = '0;
      {sel_n, row_n, col_n, wr_n} = pins;
      bank_addr = 2'(b);
      addr_b10 = ap;
      for (int k = 0; k < 4; k++)
         if (m_open[k] && (now - act_t[k] == E_OMAX + 1)) e[2] = 1'b1;
      if (now - ref_t == E_REFI + 1) e[1] = 1'b1;
      if (!pins[3]) begin
         case (pins[2:0])
            3'b011: begin
               if (now - act_t[b] < E_ACTACT) e[4] = 1'b1;
               if (now - pre_t[b] < E_PREACT) e[5] = 1'b1;
               if (m_open[b]) e[0] = 1'b1;
               act_t[b] = now;
               m_open[b] = 1'b1;
            end
            3'b101, 3'b100: begin
               if (!m_open[b]) e[0] = 1'b1;
               else if (now - act_t[b] < E_ACTRW) e[6] = 1'b1;
            end
            3'b010: begin
               for (int k = 0; k < 4; k++) begin
                  if ((ap || k == b) && m_open[k]) begin
                     if (now - act_t[k] < E_OMIN) e[3] = 1'b1;
                     m_open[k] = 1'b0;
                     pre_t[k] = now;
                  end
               end
            end
            3'b001: begin
               if (m_open[0] || m_open[1] || m_open[2] || m_open[3]) e[0] = 1'b1;
               ref_t = now;
            end
            default: ;
         endcase
      end
      eopen = {m_open[3], m_open[2], m_open[1], m_open[0]};
      @(posedge clk);
      @(negedge clk);
      cyc = now;
      checks++;
      if (got_vec() !== e || bank_open !== eopen) begin
         errors++;
         for (int k = 0; k < 7; k++)
            if (got_vec()[6-k] !== e[6-k])
               $display("FAIL %s [%s] cyc %0d flag %0d got %b exp %b",
                        tags[k], ctx, cyc, k, got_vec()[6-k], e[6-k]);
         if (bank_open !== eopen)
            $display("FAIL R2 [%s] cyc %0d bank_open got %b exp %b", ctx, cyc, bank_open, eopen);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0, "idle");
   endtask

   task automatic expect_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s got %b exp %b at cyc %0d", req, act, exp, cyc);
      end
   endtask

   task automatic expect_vec(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s got %b exp %b at cyc %0d", req, act, exp, cyc);
      end
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin
         act_t[k] = -1000000;
         pre_t[k] = -1000000;
         m_open[k] = 1'b0;
      end
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // Reset state
      expect_vec("R2 reset bank_open", bank_open, 4'b0000);
      expect_bit("R9 reset flags", |got_vec(), 1'b0);

      issue(C_REF, 0, 0, "R8 first refresh");
      expect_bit("R9 refresh with banks closed", err_protocol, 1'b0);
      idle(2);
      issue(C_ACT, 0, 0, "R2 act b0");
      expect_vec("R2 act opens bank 0", bank_open, 4'b0001);
      issue(C_RD, 0, 0, "R3 read d1");
      expect_bit("R3 read one cycle after activate", err_act_to_rw, 1'b1);
      issue(C_WR, 0, 0, "R10 write d2");
      expect_bit("R10 limit 2.5 cycles rounds up to 3", err_act_to_rw, 1'b1);
      issue(C_RD, 0, 0, "R3 read d3");
      expect_bit("R3 read at limit legal", err_act_to_rw, 1'b0);
      issue(C_PRE, 0, 0, "R6 early precharge");
      expect_bit("R6 row closed too soon", err_open_short, 1'b1);
      issue(C_ACT, 0, 0, "R4 R5 early act");
      expect_bit("R4 activate right after precharge", err_pre_to_act, 1'b1);
      expect_bit("R5 activate inside row cycle", err_act_to_act, 1'b1);
      issue(C_ACT, 0, 0, "R9 act open bank");
      expect_bit("R9 activate to open bank", err_protocol, 1'b1);
      issue(C_ACT, 2, 0, "R2 act b2");
      expect_vec("R2 two banks open", bank_open, 4'b0101);
      issue({1'b1, C_PRE[2:0]}, 0, 1, "R1 deselected precharge");
      expect_vec("R1 deselected command ignored", bank_open, 4'b0101);
      issue(C_MRS, 1, 1, "R1 undecoded pattern");
      expect_bit("R1 undecoded pattern raises nothing", err_protocol, 1'b0);
      issue(C_REF, 0, 0, "R9 refresh open");
      expect_bit("R9 refresh while bank open", err_protocol, 1'b1);
      issue(C_PRE, 3, 1, "R2 precharge all");
      expect_vec("R2 all-bank precharge", bank_open, 4'b0000);
      issue(C_PRE, 1, 0, "R11 idle precharge");
      expect_bit("R11 precharge to idle bank no flag", |got_vec()[6:3], 1'b0);
      issue(C_ACT, 1, 0, "R11 act after idle pre");
      expect_bit("R11 idle precharge does not restart timer", err_pre_to_act, 1'b0);
      issue(C_RD, 3, 0, "R9 read closed");
      expect_bit("R9 read to closed bank", err_protocol, 1'b1);
      issue(C_PRE, 1, 0, "close b1");
      issue(C_ACT, 3, 0, "R7 open b3");
      idle(E_OMAX);
      expect_bit("R7 open exactly max legal", err_open_long, 1'b0);
      issue(C_BST, 0, 0, "R7 edge");
      expect_bit("R7 open past max flagged", err_open_long, 1'b1);
      issue(C_NOP, 0, 0, "R7 after");
      expect_bit("R7 single pulse", err_open_long, 1'b0);
      issue(C_PRE, 0, 1, "close all");
      issue(C_REF, 0, 0, "R8 restart");
      idle(E_REFI);
      expect_bit("R8 interval exactly limit legal", err_refresh_late, 1'b0);
      issue(C_NOP, 0, 0, "R8 edge");
      expect_bit("R8 late refresh flagged", err_refresh_late, 1'b1);
      issue(C_NOP, 0, 0, "R8 after");
      expect_bit("R8 single pulse", err_refresh_late, 1'b0);

      // Constrained random traffic against the timestamp model (R1..R11).
      for (int i = 0; i < 4000; i++) begin
         int r;
         int b;
         bit ap;
         r  = int'($urandom % 16);
         b  = int'($urandom % 4);
         ap = 1'($urandom % 4 == 0);
         if (r < 6)       issue(C_NOP, b, ap, "rand");
         else if (r < 8)  issue(C_ACT, b, ap, "rand");
         else if (r == 8) issue(C_RD, b, ap, "rand");
         else if (r == 9) issue(C_WR, b, ap, "rand");
         else if (r < 12) issue(C_PRE, b, ap, "rand");
         else if (r == 12) issue(C_REF, b, ap, "rand");
         else if (r == 13) issue({1'b1, 3'($urandom)}, b, ap, "rand R1");
         else if (r == 14) issue(C_MRS, b, ap, "rand R1");
         else issue(C_BST, b, ap, "rand R1");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at cyc %0d", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule